// File: doc/BRIEF.md
# Packed String Compare Unit

This block compares two 128-bit packed character fragments in a single pass. The first operand is the reference. Depending on the mode it is a set of characters, a list of inclusive range bounds, or a needle to search for. The second operand is the subject text being examined. One control bit chooses between byte characters and 16-bit characters. A two-bit mode field chooses how an all-pairs grid of character comparisons is reduced into a per-character match mask.

Each operand comes with a valid-length input, so the unit handles fragments that are only partly filled. A caller presents both operands, the mode, the size bit and the two lengths, and pulses `in_valid`. One cycle later the unit returns three registered results together with a single-cycle `out_valid` pulse:

- the match mask;
- the position of the lowest set mask bit;
- a flag that says no bit is set.

Walking a long string across fragments is left to the surrounding logic.

Top module: `packed_str_cmp`

## Requirements
- R1: With `wide_chars`=0 each operand holds sixteen 8-bit characters, character i at bits [8i+7:8i]. With `wide_chars`=1 it holds eight 16-bit characters, character i at bits [16i+15:16i], and all 16 bits take part in a comparison.
- R2: The valid character count of an operand is min(length, N), where N is 16 for bytes and 8 for 16-bit characters. A subject character at or beyond its count never sets its mask bit.
- R3: Mode 0 (lane equality): mask bit i is set when subject character i and reference character i are both valid and equal.
- R4: Mode 1 (set membership): mask bit i is set when valid subject character i equals any valid reference character.
- R5: Mode 2 (range membership): reference characters 2p and 2p+1 form pair p, holding an inclusive lower bound and an inclusive upper bound. Several pairs may be active at once. Mask bit i is set when valid subject character i lies in at least one pair whose two characters are both valid. An unpaired last valid character is ignored, and a pair whose lower bound exceeds its upper bound matches nothing.
- R6: Mode 3 (ordered search): mask bit i is set when subject position i is valid and, for every valid needle character k, either subject position i+k is beyond the valid subject or subject character i+k equals needle character k. Partial matches at the end of the fragment are therefore reported.
- R7: In mode 3, an empty needle (reference count 0) sets the mask bit of every valid subject position.
- R8: `out_index` is the position of the lowest set mask bit. When the mask is zero, `out_index` equals N (16 or 8) and `out_none` is 1; otherwise `out_none` is 0.
- R9: With `wide_chars`=1, mask bits 15..8 are always zero.
- R10: Results appear on the clock edge after the edge that samples `in_valid`=1, with `out_valid` high for exactly that cycle. Back-to-back requests are accepted on consecutive cycles. Without a request, `out_mask`, `out_index` and `out_none` hold their values.
- R11: Synchronous active-high reset clears `out_valid`, `out_mask`, `out_index` and `out_none` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe; the inputs are sampled while it is high |
| wide_chars | input | 1 | 0: byte characters, 1: 16-bit characters |
| mode | input | 2 | 0 lane equality, 1 set membership, 2 range pairs, 3 ordered search |
| ref_data | input | 128 | Reference operand (set, range bounds or needle) |
| ref_len | input | 5 | Valid character count of the reference |
| sub_data | input | 128 | Subject text operand |
| sub_len | input | 5 | Valid character count of the subject |
| out_valid | output | 1 | One-cycle result strobe |
| out_mask | output | 16 | Per-character match mask |
| out_index | output | 5 | Lowest set mask position, or N when there is none |
| out_none | output | 1 | Mask is all zero |

## Verification
The bench targets the fragment boundary in ordered search. A needle whose tail hangs past the valid subject must still report the position. A design that demands a full match there would lose the partial hit, and one that ignores `sub_len` would match on stale bytes.

Range mode is driven with several pairs, with an odd reference count and with an inverted pair. A design that pairs bounds wrongly, or that turns the dangling character into a bound, produces extra mask bits. Empty and oversize lengths, an all-miss mask, and 16-bit characters that differ only in their upper byte check three things: the clamping, the N-valued index, and that the compare really spans 16 bits. Back-to-back requests check that no result is dropped or duplicated.

// File: rtl/psc_pkg.sv
package psc_pkg;
  typedef enum logic [1:0] {
    CMP_EACH  = 2'd0,
    CMP_ANY   = 2'd1,
    CMP_RANGE = 2'd2,
    CMP_ORDER = 2'd3
  } cmp_mode_e;
endpackage

// File: rtl/psc_lanes.sv
// Splits a packed fragment into characters and marks the valid ones.
module psc_lanes #(
  parameter int NB = 16,
  parameter int LW = 5,
  parameter int CW = 16
) (
  input  logic [8*NB-1:0]        data,
  input  logic                   wide,
  input  logic [LW-1:0]          len,
  output logic [NB-1:0][CW-1:0]  chars,
  output logic [NB-1:0]          ok
);
  localparam int HALF = NB / 2;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    localparam int I = g;
    if (I < HALF) begin : g_both
      assign chars[g] = wide ? data[16*I +: 16] : {8'h00, data[8*I +: 8]};
    end else begin : g_narrow
      assign chars[g] = wide ? '0 : {8'h00, data[8*I +: 8]};
    end
    assign ok[g] = (32'(len) > I) && (wide ? (I < HALF) : 1'b1);
  end
endmodule

// File: rtl/psc_grid.sv
// All-pairs comparison grid: [s][r] relates subject s to reference r.
module psc_grid #(
  parameter int NB = 16,
  parameter int CW = 16
) (
  input  logic [NB-1:0][CW-1:0] sub_c,
  input  logic [NB-1:0][CW-1:0] ref_c,
  output logic [NB-1:0][NB-1:0] eq,
  output logic [NB-1:0][NB-1:0] ge,
  output logic [NB-1:0][NB-1:0] le
);
  for (genvar s = 0; s < NB; s++) begin : g_row
    for (genvar r = 0; r < NB; r++) begin : g_col
      assign eq[s][r] = (sub_c[s] == ref_c[r]);
      assign ge[s][r] = (sub_c[s] >= ref_c[r]);
      assign le[s][r] = (sub_c[s] <= ref_c[r]);
    end
  end
endmodule

// File: rtl/psc_reduce.sv
// Folds the comparison grid into a mask according to the mode.
module psc_reduce
  import psc_pkg::*;
#(
  parameter int NB = 16
) (
  input  logic [1:0]            mode,
  input  logic [NB-1:0][NB-1:0] eq,
  input  logic [NB-1:0][NB-1:0] ge,
  input  logic [NB-1:0][NB-1:0] le,
  input  logic [NB-1:0]         sub_ok,
  input  logic [NB-1:0]         ref_ok,
  output logic [NB-1:0]         mask
);
  localparam int NP = NB / 2;

  cmp_mode_e md;
  assign md = cmp_mode_e'(mode);

  always_comb begin
    for (int i = 0; i < NB; i++) begin
      logic hit;
      hit = 1'b0;
      unique case (md)
        CMP_EACH: hit = ref_ok[i] && eq[i][i];
        CMP_ANY: begin
          for (int j = 0; j < NB; j++)
            if (ref_ok[j] && eq[i][j]) hit = 1'b1;
        end
        CMP_RANGE: begin
          for (int p = 0; p < NP; p++)
            if (ref_ok[2*p+1] && ge[i][2*p] && le[i][2*p+1]) hit = 1'b1;
        end
        CMP_ORDER: begin
          hit = 1'b1;
          for (int k = 0; k < NB; k++) begin
            if (i + k < NB) begin
              if (ref_ok[k] && sub_ok[i+k] && !eq[i+k][k]) hit = 1'b0;
            end
          end
        end
        default: hit = 1'b0;
      endcase
      mask[i] = sub_ok[i] && hit;
    end
  end
endmodule

// File: rtl/psc_first.sv
// Lowest-set-bit encoder with element-count fallback.
module psc_first #(
  parameter int NB = 16,
  parameter int IW = 5
) (
  input  logic [NB-1:0] mask,
  input  logic          wide,
  output logic [IW-1:0] idx,
  output logic          none
);
  always_comb begin
    idx = wide ? IW'(NB / 2) : IW'(NB);
    for (int i = NB - 1; i >= 0; i--)
      if (mask[i]) idx = IW'(i);
    none = ~|mask;
  end
endmodule

// File: rtl/packed_str_cmp.sv
module packed_str_cmp
  import psc_pkg::*;
#(
  parameter int NB = 16,
  parameter int LW = 5,
  parameter int IW = $clog2(NB) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              wide_chars,
  input  logic [1:0]        mode,
  input  logic [8*NB-1:0]   ref_data,
  input  logic [LW-1:0]     ref_len,
  input  logic [8*NB-1:0]   sub_data,
  input  logic [LW-1:0]     sub_len,
  output logic              out_valid,
  output logic [NB-1:0]     out_mask,
  output logic [IW-1:0]     out_index,
  output logic              out_none
);
  localparam int CW = 16;

  logic [NB-1:0][CW-1:0] ref_c, sub_c;
  logic [NB-1:0]         ref_ok, sub_ok;
  logic [NB-1:0][NB-1:0] eq, ge, le;
  logic [NB-1:0]         mask_c;
  logic [IW-1:0]         idx_c;
  logic                  none_c;

  psc_lanes #(.NB(NB), .LW(LW), .CW(CW)) u_ref_lanes (
    .data(ref_data), .wide(wide_chars), .len(ref_len), .chars(ref_c), .ok(ref_ok));

  psc_lanes #(.NB(NB), .LW(LW), .CW(CW)) u_sub_lanes (
    .data(sub_data), .wide(wide_chars), .len(sub_len), .chars(sub_c), .ok(sub_ok));

  psc_grid #(.NB(NB), .CW(CW)) u_grid (
    .sub_c(sub_c), .ref_c(ref_c), .eq(eq), .ge(ge), .le(le));

  psc_reduce #(.NB(NB)) u_reduce (
    .mode(mode), .eq(eq), .ge(ge), .le(le),
    .sub_ok(sub_ok), .ref_ok(ref_ok), .mask(mask_c));

  psc_first #(.NB(NB), .IW(IW)) u_first (
    .mask(mask_c), .wide(wide_chars), .idx(idx_c), .none(none_c));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_mask  <= '0;
      out_index <= '0;
      out_none  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_mask  <= mask_c;
        out_index <= idx_c;
        out_none  <= none_c;
      end
    end
  end

  // R10: result strobe follows the request by one cycle
  a_r10_latency: assert property (@(posedge clk) disable iff (rst)
    out_valid == $past(in_valid));

  // R10: outputs hold without a request
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_mask) && $stable(out_index) && $stable(out_none)));

  // R8: no-match flag tracks an empty mask
  a_r8_none_flag: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_none == (out_mask == '0)));

  // R8: index on an empty mask is the element count
  a_r8_none_index: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_none) |->
      (out_index == ($past(wide_chars) ? IW'(NB / 2) : IW'(NB))));

  // R8: index points at the lowest set bit
  a_r8_lowest: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_none) |->
      (out_mask[out_index] && ((out_mask & ~({NB{1'b1}} << out_index)) == '0)));

  // R9: upper mask half is zero for 16-bit characters
  a_r9_wide_upper: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(wide_chars)) |-> (out_mask[NB-1:NB/2] == '0));

  // R2: no mask bit at or beyond the subject length
  a_r2_sub_len: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((out_mask >> $past(sub_len)) == '0));
endmodule

// File: tb/packed_str_cmp_test.sv
module packed_str_cmp_test;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         wide_chars = 1'b0;
  logic [1:0]   mode = 2'd0;
  logic [127:0] ref_data = '0;
  logic [4:0]   ref_len = '0;
  logic [127:0] sub_data = '0;
  logic [4:0]   sub_len = '0;
  logic         out_valid;
  logic [15:0]  out_mask;
  logic [4:0]   out_index;
  logic         out_none;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [15:0] q_mask[$];
  logic [4:0]  q_idx[$];
  logic        q_none[$];
  string       q_tag[$];
  logic [15:0] last_mask;
  logic [4:0]  last_idx;
  logic        last_none;

  always #4 clk = ~clk;

  packed_str_cmp uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .wide_chars(wide_chars),
    .mode(mode), .ref_data(ref_data), .ref_len(ref_len),
    .sub_data(sub_data), .sub_len(sub_len), .out_valid(out_valid),
    .out_mask(out_mask), .out_index(out_index), .out_none(out_none));

  function automatic logic [127:0] pk(string s);
    logic [127:0] r = '0;
    for (int i = 0; i < s.len() && i < 16; i++) r[8*i +: 8] = s[i];
    return r;
  endfunction

  function automatic logic [127:0] pkw(string s, logic [7:0] hi);
    logic [127:0] r = '0;
    for (int i = 0; i < s.len() && i < 8; i++) r[16*i +: 16] = {hi, s[i]};
    return r;
  endfunction

  function automatic logic [15:0] chr(logic [127:0] d, bit w, int i);
    return w ? d[16*i +: 16] : {8'h00, d[8*i +: 8]};
  endfunction

  task automatic send(input logic [1:0] md, input bit w, input logic [127:0] rd,
                      input int rl, input logic [127:0] sd, input int sl,
                      input string tag);
    int n, sv, rv;
    logic [15:0] m;
    logic [4:0] ix;
    n  = w ? 8 : 16;
    sv = (sl < n) ? sl : n;
    rv = (rl < n) ? rl : n;
    m  = '0;
    for (int i = 0; i < sv; i++) begin
      bit hit = 1'b0;
      case (md)
        2'd0: hit = (i < rv) && (chr(sd, w, i) == chr(rd, w, i));
        2'd1: for (int j = 0; j < rv; j++) if (chr(sd, w, i) == chr(rd, w, j)) hit = 1'b1;
        2'd2: for (int p = 0; 2*p+1 < rv; p++)
                if (chr(sd, w, i) >= chr(rd, w, 2*p) && chr(sd, w, i) <= chr(rd, w, 2*p+1)) hit = 1'b1;
        default: begin
          hit = 1'b1;
          for (int k = 0; k < rv; k++)
            if (i + k < sv && chr(sd, w, i+k) != chr(rd, w, k)) hit = 1'b0;
        end
      endcase
      m[i] = hit;
    end
    ix = 5'(n);
    for (int i = n - 1; i >= 0; i--) if (m[i]) ix = 5'(i);
    @(negedge clk);
    in_valid = 1'b1; mode = md; wide_chars = w;
    ref_data = rd; ref_len = 5'(rl); sub_data = sd; sub_len = 5'(sl);
    q_mask.push_back(m); q_idx.push_back(ix); q_none.push_back(m == '0); q_tag.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && out_valid && !done) begin
      tests++;
      if (q_mask.size() == 0) begin
        fails++;
        $display("FAIL R10 unexpected result mask=%h expected no result", out_mask);
      end else begin
        logic [15:0] em; logic [4:0] ei; logic en; string t;
        em = q_mask.pop_front(); ei = q_idx.pop_front();
        en = q_none.pop_front(); t = q_tag.pop_front();
        if (out_mask !== em || out_index !== ei || out_none !== en) begin
          fails++;
          $display("FAIL %s mask=%h idx=%0d none=%0b expected mask=%h idx=%0d none=%0b",
                   t, out_mask, out_index, out_none, em, ei, en);
        end
      end
      last_mask = out_mask; last_idx = out_index; last_none = out_none;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    tests++;
    if (out_valid !== 1'b0 || out_mask !== '0 || out_index !== '0 || out_none !== 1'b0) begin
      fails++;
      $display("FAIL R11 reset v=%0b m=%h i=%0d n=%0b expected all zero",
               out_valid, out_mask, out_index, out_none);
    end
    rst = 1'b0;
    idle();

    // R3 lane equality
    send(2'd0, 1'b0, pk("hello world!abcd"), 16, pk("hellO wOrld!abXd"), 16, "R3");
    idle();
    // R3 + R2 reference shorter than subject
    send(2'd0, 1'b0, pk("abcdefgh"), 4, pk("abcdefgh"), 8, "R3");
    idle();
    // R4 vowel set
    send(2'd1, 1'b0, pk("aeiouy"), 6, pk("the quick brown "), 16, "R4");
    idle();
    // R5 two pairs: lower and upper case
    send(2'd2, 1'b0, pk("azAZ"), 4, pk("Hi 5 World 42 ok"), 16, "R5");
    idle();
    // R5 odd count: dangling '0' ignored
    send(2'd2, 1'b0, pk("az0"), 3, pk("09az"), 4, "R5");
    idle();
    // R5 inverted pair matches nothing
    send(2'd2, 1'b0, pk("za"), 2, pk("mmmm"), 4, "R5");
    idle();
    // R6 substring search, back-to-back requests (R10)
    send(2'd3, 1'b0, pk("lo"), 2, pk("hello lo yolo ok"), 16, "R6");
    send(2'd3, 1'b0, pk("abc"), 3, pk("xxxxxxxxxxxxxxab"), 16, "R6");
    send(2'd3, 1'b0, pk("abc"), 3, pk("xxxxabxxxxxxxxxx"), 6, "R6");
    idle();
    // R7 empty needle
    send(2'd3, 1'b0, pk("zz"), 0, pk("anything"), 5, "R7");
    idle();
    // R8 no match in byte mode -> index 16
    send(2'd1, 1'b0, pk("q"), 1, pk("abcdefghijklmnop"), 16, "R8");
    idle();
    // R2 empty subject and oversize lengths clamp
    send(2'd3, 1'b0, pk(""), 0, pk("abc"), 0, "R2");
    send(2'd0, 1'b0, pk("abcdefghijklmnop"), 20, pk("abcdefghijklmnop"), 31, "R2");
    idle();
    // R1 / R9 wide equality, upper byte differs
    send(2'd0, 1'b1, pkw("abcdefgh", 8'h31), 8, pkw("abcdefgh", 8'h32), 8, "R1");
    send(2'd0, 1'b1, pkw("abcdefgh", 8'h31), 8, pkw("abcdefgh", 8'h31), 20, "R9");
    send(2'd3, 1'b1, pkw("gh", 8'h05), 2, pkw("ghxxghxg", 8'h05), 8, "R6");
    idle();
    // R8 wide no match -> index 8
    send(2'd1, 1'b1, pkw("z", 8'h00), 1, pk("abcdefghijklmnop"), 16, "R8");
    idle();

    // Mixed small-alphabet sweep
    for (int v = 0; v < 400; v++) begin
      logic [127:0] rd, sd;
      logic [1:0] md;
      bit w;
      string tg;
      rd = '0; sd = '0;
      w  = 1'($urandom_range(0, 1));
      md = 2'($urandom_range(0, 3));
      for (int b = 0; b < 16; b++) begin
        rd[8*b +: 8] = 8'($urandom_range(97, 100));
        sd[8*b +: 8] = 8'($urandom_range(97, 100));
        if (w && b % 2 == 1) begin rd[8*b +: 8] = 8'h00; sd[8*b +: 8] = 8'h00; end
      end
      case (md)
        2'd0: tg = "R3";
        2'd1: tg = "R4";
        2'd2: tg = "R5";
        default: tg = "R6";
      endcase
      send(md, w, rd, $urandom_range(0, 20), sd, $urandom_range(0, 20), tg);
      if (v % 3 == 0) idle();
    end
    idle();
    repeat (4) @(negedge clk);

    // R10 outputs hold after the last result
    tests++;
    if (out_mask !== last_mask || out_index !== last_idx || out_none !== last_none || out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R10 hold mask=%h idx=%0d expected mask=%h idx=%0d",
               out_mask, out_index, last_mask, last_idx);
    end
    // R10 every request produced exactly one result
    tests++;
    if (q_mask.size() != 0) begin
      fails++;
      $display("FAIL R10 pending results %0d expected 0", q_mask.size());
    end

    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule